// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block walks an SDRAM device from power-up to normal operation. After a start pulse it emits a fixed script of steps. Each step is one of four things: raise the clock-enable level, issue a one-hot command, load a mode-register value, or load an extended-mode value. The last step loads the refresh interval. Between steps the block waits a set number of microsecond ticks.

Two scripts are built in, and the memory-type select input chooses between them when the start pulse is taken. The second-generation script adds the EMR2 and EMR3 loads after the first precharge. It also adds, near the end, an off-chip-driver default load followed by a reload of the normal extended value. Both scripts write the mode register twice: first with the DLL-reset bit set, then with it clear.

Each step appears on the output port for exactly one cycle as a strobe, a step kind, a command code and a value. A controller or a pad sequencer downstream turns these into pin activity. Completion is shown by a ready level and by the loaded refresh interval.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, busy_o, ready_o, cke_o and op_stb_o are 0, and op_kind_o reads 0 (no step).
- R2: Command codes on op_cmd_o are one-hot: mode write 0x01, extended-mode write 0x02, auto refresh 0x04, precharge-all 0x08, EMR2 load 0x10, EMR3 load 0x20. op_cmd_o is 0 on every step that is not a command.
- R3: type_ddr1_i is sampled only when a start pulse is accepted: 1 selects the first-generation script and 0 selects the second-generation script. Changing it while busy has no effect on the script being run.
- R4: The second-generation script runs these steps in order: clock enable (kind 1), precharge-all, EMR2, EMR3, extended load 0x402 (kind 4), extended write, mode load 0x143 (kind 3), mode write, precharge-all, auto refresh, auto refresh, mode load 0x043, mode write, extended load 0x782, extended write, extended load 0x402, extended write, refresh load (kind 5). Command steps use kind 2.
- R5: The first-generation script uses the same order without the EMR2 and EMR3 steps and without the four 0x782/0x402 steps near the end. Its extended value is 0x000.
- R6: The first mode load carries the DLL-reset bit (0x143 for the second generation, 0x133 for the first). The second mode load has that bit clear (0x043 and 0x033).
- R7: After each strobe the block counts us_tick_i pulses seen in the following cycles, and the next strobe (or ready) comes in the cycle after the Nth one. N is 1000 after the DLL-reset mode load. N is 100 after the clock enable, after every register load, and after the mode write and extended writes that follow the second mode load. N is 10 after every other command.
- R8: The refresh load step carries refresh_cfg_i on op_val_o and copies it into refresh_o. ready_o rises when the wait after that step ends, and busy_o falls in the same cycle.
- R9: A start pulse while busy_o is 1 is ignored, and the script in progress runs unchanged.
- R10: op_stb_o is never high for two cycles in a row. cke_o goes high with the clock-enable step and stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start pulse; accepted only while not busy |
| type_ddr1_i | input | 1 | Memory type select: 1 selects first generation, 0 selects second |
| us_tick_i | input | 1 | One-cycle pulse once per microsecond |
| refresh_cfg_i | input | REF_W (16) | Refresh interval to load at the final step |
| busy_o | output | 1 | Script in progress |
| ready_o | output | 1 | Script finished; held until the next start |
| cke_o | output | 1 | Clock-enable level for the device |
| op_stb_o | output | 1 | One-cycle step strobe |
| op_kind_o | output | 3 | Step kind: 0 none, 1 clock enable, 2 command, 3 mode load, 4 extended load, 5 refresh load |
| op_cmd_o | output | 6 | One-hot command code; 0 unless kind is 2 |
| op_val_o | output | VAL_W (16) | Register value for kinds 3, 4 and 5; otherwise 0 |
| refresh_o | output | REF_W (16) | Loaded refresh interval |

## Verification
The timer assertions assume that us_tick_i is a single-cycle pulse and that the configured wait lengths are at least 1. A wait of zero would never expire. The bench drives one tick every fourth cycle, so the cycle that carries a strobe is never the cycle that ends a wait. The type-select and start inputs change only between clock edges, and the extra start pulse in the disturbance run falls inside a long wait. This means the script under test is the one latched at the first accepted start.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int NSTEP = 18;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_CKE  = 3'd1,
    OP_CMD  = 3'd2,
    OP_MODE = 3'd3,
    OP_EXT  = 3'd4,
    OP_REFR = 3'd5
  } op_kind_e;

  typedef enum logic [1:0] {
    WT_CMD  = 2'd0,
    WT_LOAD = 2'd1,
    WT_DLL  = 2'd2
  } wait_cls_e;

  localparam logic [5:0] C_MRS  = 6'h01;
  localparam logic [5:0] C_EMRS = 6'h02;
  localparam logic [5:0] C_AREF = 6'h04;
  localparam logic [5:0] C_PREA = 6'h08;
  localparam logic [5:0] C_EMR2 = 6'h10;
  localparam logic [5:0] C_EMR3 = 6'h20;

  // steps present only in the second-generation script
  function automatic logic gen2_only_step(input int unsigned i);
    return (i == 2) || (i == 3) || ((i >= 13) && (i <= 16));
  endfunction

endpackage

// File: rtl/sdram_init_rom.sv
module sdram_init_rom
  import sdram_init_pkg::*;
#(
  parameter int VAL_W          = 16,
  parameter int IDX_W          = 5,
  parameter logic [15:0] MR_DLL_G2 = 16'h0143,
  parameter logic [15:0] MR_RUN_G2 = 16'h0043,
  parameter logic [15:0] MR_DLL_G1 = 16'h0133,
  parameter logic [15:0] MR_RUN_G1 = 16'h0033,
  parameter logic [15:0] EXT_G2    = 16'h0402,
  parameter logic [15:0] EXT_G1    = 16'h0000,
  parameter logic [15:0] EXT_OCD   = 16'h0782
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             ddr1,
  input  logic [VAL_W-1:0] refr_val,
  output op_kind_e         kind,
  output logic [5:0]       cmd,
  output logic [VAL_W-1:0] val,
  output wait_cls_e        wsel,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             last
);

  logic [VAL_W-1:0] mr_dll, mr_run, ext_norm, ext_ocd;

  assign mr_dll   = VAL_W'(ddr1 ? MR_DLL_G1 : MR_DLL_G2);
  assign mr_run   = VAL_W'(ddr1 ? MR_RUN_G1 : MR_RUN_G2);
  assign ext_norm = VAL_W'(ddr1 ? EXT_G1 : EXT_G2);
  assign ext_ocd  = VAL_W'(EXT_OCD);

  always_comb begin
    kind = OP_NONE;
    cmd  = '0;
    val  = '0;
    wsel = WT_CMD;
    case (idx)
      5'd0:  begin kind = OP_CKE;  wsel = WT_LOAD; end
      5'd1:  begin kind = OP_CMD;  cmd = C_PREA; end
      5'd2:  begin kind = OP_CMD;  cmd = C_EMR2; end
      5'd3:  begin kind = OP_CMD;  cmd = C_EMR3; end
      5'd4:  begin kind = OP_EXT;  val = ext_norm; wsel = WT_LOAD; end
      5'd5:  begin kind = OP_CMD;  cmd = C_EMRS; end
      5'd6:  begin kind = OP_MODE; val = mr_dll; wsel = WT_DLL; end
      5'd7:  begin kind = OP_CMD;  cmd = C_MRS; end
      5'd8:  begin kind = OP_CMD;  cmd = C_PREA; end
      5'd9:  begin kind = OP_CMD;  cmd = C_AREF; end
      5'd10: begin kind = OP_CMD;  cmd = C_AREF; end
      5'd11: begin kind = OP_MODE; val = mr_run; wsel = WT_LOAD; end
      5'd12: begin kind = OP_CMD;  cmd = C_MRS;  wsel = WT_LOAD; end
      5'd13: begin kind = OP_EXT;  val = ext_ocd; wsel = WT_LOAD; end
      5'd14: begin kind = OP_CMD;  cmd = C_EMRS; wsel = WT_LOAD; end
      5'd15: begin kind = OP_EXT;  val = ext_norm; wsel = WT_LOAD; end
      5'd16: begin kind = OP_CMD;  cmd = C_EMRS; wsel = WT_LOAD; end
      5'd17: begin kind = OP_REFR; val = refr_val; wsel = WT_LOAD; end
      default: begin kind = OP_NONE; end
    endcase
  end

  // next index: smallest later step that belongs to the selected script
  always_comb begin
    logic found;
    found   = 1'b0;
    nxt_idx = '0;
    for (int k = NSTEP - 1; k >= 0; k--) begin
      if ((k > int'(idx)) && !(ddr1 && gen2_only_step(unsigned'(k)))) begin
        nxt_idx = IDX_W'(k);
        found   = 1'b1;
      end
    end
    last = !found;
  end

endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (tick && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (tick && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign expire = !load && tick && (cnt_q == CNT_W'(1));

  // R7
  tmr_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));

  // R7
  tmr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (cnt_q == '0)) |=> (cnt_q == '0));

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 10,
  parameter int REF_W     = 16,
  parameter int W_CMD_US  = 10,
  parameter int W_LOAD_US = 100,
  parameter int W_DLL_US  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             type_sel,
  input  logic [REF_W-1:0] refr_cfg,
  input  op_kind_e         kind,
  input  wait_cls_e        wsel,
  input  logic [IDX_W-1:0] nxt_idx,
  input  logic             last,
  input  logic             tmr_expire,
  output logic [IDX_W-1:0] idx,
  output logic             ddr1,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             op_stb,
  output logic             busy,
  output logic             ready,
  output logic             cke,
  output logic [REF_W-1:0] refresh
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_ISSUE = 2'd1, S_WAIT = 2'd2} st_e;

  st_e              st_q, st_d;
  logic [IDX_W-1:0] idx_d;
  logic             ddr1_d, ready_d, cke_d;
  logic             take;
  logic             ref_en;

  assign take   = (st_q == S_IDLE) && start;
  assign op_stb = (st_q == S_ISSUE);
  assign busy   = (st_q != S_IDLE);
  assign ref_en = op_stb && (kind == OP_REFR);

  always_comb begin
    case (wsel)
      WT_DLL:  tmr_val = CNT_W'(W_DLL_US);
      WT_LOAD: tmr_val = CNT_W'(W_LOAD_US);
      default: tmr_val = CNT_W'(W_CMD_US);
    endcase
  end

  assign tmr_load = op_stb;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx;
    ddr1_d  = ddr1;
    ready_d = ready;
    cke_d   = cke;
    case (st_q)
      S_IDLE: if (take) begin
        st_d    = S_ISSUE;
        idx_d   = '0;
        ddr1_d  = type_sel;
        ready_d = 1'b0;
        cke_d   = 1'b0;
      end
      S_ISSUE: begin
        st_d = S_WAIT;
        if (kind == OP_CKE) cke_d = 1'b1;
      end
      S_WAIT: if (tmr_expire) begin
        if (last) begin
          st_d    = S_IDLE;
          ready_d = 1'b1;
        end else begin
          st_d  = S_ISSUE;
          idx_d = nxt_idx;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx   <= '0;
      ddr1  <= 1'b0;
      ready <= 1'b0;
      cke   <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx   <= idx_d;
      ddr1  <= ddr1_d;
      ready <= ready_d;
      cke   <= cke_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      refresh <= '0;
    else if (ref_en)
      refresh <= refr_cfg;
  end

  // R10
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_stb |=> !op_stb);

  // R3
  type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ddr1));

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(tmr_expire && last)) |=> busy);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int VAL_W     = 16,
  parameter int REF_W     = 16,
  parameter int W_CMD_US  = 10,
  parameter int W_LOAD_US = 100,
  parameter int W_DLL_US  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             type_ddr1_i,
  input  logic             us_tick_i,
  input  logic [REF_W-1:0] refresh_cfg_i,
  output logic             busy_o,
  output logic             ready_o,
  output logic             cke_o,
  output logic             op_stb_o,
  output logic [2:0]       op_kind_o,
  output logic [5:0]       op_cmd_o,
  output logic [VAL_W-1:0] op_val_o,
  output logic [REF_W-1:0] refresh_o
);

  localparam int IDX_W  = $clog2(NSTEP);
  localparam int W_MAX1 = (W_CMD_US > W_LOAD_US) ? W_CMD_US : W_LOAD_US;
  localparam int W_MAX  = (W_MAX1 > W_DLL_US) ? W_MAX1 : W_DLL_US;
  localparam int CNT_W  = $clog2(W_MAX + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_in_n;
  logic [IDX_W-1:0] idx, nxt_idx;
  logic             ddr1, last, tmr_load, tmr_expire, stb;
  logic [CNT_W-1:0] tmr_val;
  op_kind_e         kind;
  wait_cls_e        wsel;
  logic [5:0]       cmd;
  logic [VAL_W-1:0] val, refr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  assign refr_val = VAL_W'(refresh_cfg_i);

  sdram_init_rom #(.VAL_W(VAL_W), .IDX_W(IDX_W)) u_rom (
    .idx      (idx),
    .ddr1     (ddr1),
    .refr_val (refr_val),
    .kind     (kind),
    .cmd      (cmd),
    .val      (val),
    .wsel     (wsel),
    .nxt_idx  (nxt_idx),
    .last     (last)
  );

  sdram_init_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_in_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (us_tick_i),
    .expire   (tmr_expire)
  );

  sdram_init_fsm #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .REF_W(REF_W),
    .W_CMD_US(W_CMD_US), .W_LOAD_US(W_LOAD_US), .W_DLL_US(W_DLL_US)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_in_n),
    .start      (start_i),
    .type_sel   (type_ddr1_i),
    .refr_cfg   (refresh_cfg_i),
    .kind       (kind),
    .wsel       (wsel),
    .nxt_idx    (nxt_idx),
    .last       (last),
    .tmr_expire (tmr_expire),
    .idx        (idx),
    .ddr1       (ddr1),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .op_stb     (stb),
    .busy       (busy_o),
    .ready      (ready_o),
    .cke        (cke_o),
    .refresh    (refresh_o)
  );

  assign op_stb_o  = stb;
  assign op_kind_o = stb ? kind : OP_NONE;
  assign op_cmd_o  = (stb && (kind == OP_CMD)) ? cmd : 6'h00;
  assign op_val_o  = stb ? val : '0;

  // R2
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    (stb && (kind == OP_CMD)) |-> ($countones(cmd) == 1));

  // R10
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    (cke_o && !(start_i && !busy_o)) |=> cke_o);

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  typedef struct packed {
    logic [2:0]  k;
    logic [5:0]  c;
    logic [15:0] v;
    logic [11:0] w;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, type_ddr1_i, us_tick_i;
  logic [15:0] refresh_cfg_i;
  logic        busy_o, ready_o, cke_o, op_stb_o;
  logic [2:0]  op_kind_o;
  logic [5:0]  op_cmd_o;
  logic [15:0] op_val_o, refresh_o;

  int   n_chk = 0, n_fail = 0;
  exp_t q[$];
  logic mon_en = 1'b0;
  int   ticks = 0;
  int   prev_w = 0;
  bit   have_prev = 0;
  logic ready_d = 1'b0;
  string ord_tag = "R4";
  bit   finished = 0;

  always #4 clk = ~clk;

  sdram_init_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .type_ddr1_i(type_ddr1_i),
    .us_tick_i(us_tick_i), .refresh_cfg_i(refresh_cfg_i), .busy_o(busy_o),
    .ready_o(ready_o), .cke_o(cke_o), .op_stb_o(op_stb_o), .op_kind_o(op_kind_o),
    .op_cmd_o(op_cmd_o), .op_val_o(op_val_o), .refresh_o(refresh_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic [2:0] k, input logic [5:0] c,
                      input logic [15:0] v, input int w);
    exp_t e;
    e.k = k; e.c = c; e.v = v; e.w = 12'(w);
    q.push_back(e);
  endtask

  // driver: expected script from the requirements, then the start pulse
  task automatic run_seq(input bit g1, input logic [15:0] refr, input bit disturb);
    ord_tag = g1 ? "R5" : "R4";
    push(3'd1, 6'h00, 16'h0000, 100);
    push(3'd2, 6'h08, 16'h0000, 10);
    if (!g1) begin
      push(3'd2, 6'h10, 16'h0000, 10);
      push(3'd2, 6'h20, 16'h0000, 10);
    end
    push(3'd4, 6'h00, g1 ? 16'h0000 : 16'h0402, 100);
    push(3'd2, 6'h02, 16'h0000, 10);
    push(3'd3, 6'h00, g1 ? 16'h0133 : 16'h0143, 1000);
    push(3'd2, 6'h01, 16'h0000, 10);
    push(3'd2, 6'h08, 16'h0000, 10);
    push(3'd2, 6'h04, 16'h0000, 10);
    push(3'd2, 6'h04, 16'h0000, 10);
    push(3'd3, 6'h00, g1 ? 16'h0033 : 16'h0043, 100);
    push(3'd2, 6'h01, 16'h0000, 100);
    if (!g1) begin
      push(3'd4, 6'h00, 16'h0782, 100);
      push(3'd2, 6'h02, 16'h0000, 100);
      push(3'd4, 6'h00, 16'h0402, 100);
      push(3'd2, 6'h02, 16'h0000, 100);
    end
    push(3'd5, 6'h00, refr, 100);

    @(posedge clk); #1;
    type_ddr1_i   = g1;
    refresh_cfg_i = refr;
    start_i       = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    check(busy_o == 1'b1, "R9 busy after start", 32'(busy_o), 32'd1);
    check(ready_o == 1'b0, "R8 ready cleared by start", 32'(ready_o), 32'd0);
    if (disturb) begin
      repeat (60) @(posedge clk);
      #1;
      type_ddr1_i = ~g1;
      start_i     = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      @(negedge clk);
      check(busy_o == 1'b1, "R9 second start ignored", 32'(busy_o), 32'd1);
    end
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    check(q.size() == 0, ord_tag, 32'(q.size()), 32'd0);
    check(refresh_o == refr, "R8 refresh loaded", 32'(refresh_o), 32'(refr));
    check(busy_o == 1'b0 && ready_o == 1'b1, "R8 done state",
          {30'd0, busy_o, ready_o}, 32'd1);
    check(cke_o == 1'b1, "R10 cke held", 32'(cke_o), 32'd1);
  endtask

  // tick source: one pulse every fourth cycle
  initial begin
    int tc;
    tc = 0;
    us_tick_i = 1'b0;
    forever begin
      @(posedge clk); #1;
      tc++;
      us_tick_i = (tc % 4 == 0);
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      if (op_stb_o) begin
        if (have_prev)
          check(ticks == prev_w, "R7 wait length", 32'(ticks), 32'(prev_w));
        if (q.size() == 0) begin
          check(1'b0, ord_tag, 32'(op_kind_o), 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(op_kind_o == e.k, ord_tag, 32'(op_kind_o), 32'(e.k));
          check(op_cmd_o == e.c, "R2 command code", 32'(op_cmd_o), 32'(e.c));
          check(op_val_o == e.v, (e.k == 3'd3) ? "R6 mode value" : ord_tag,
                32'(op_val_o), 32'(e.v));
          if (e.k == 3'd1)
            check(cke_o == 1'b0, "R10 cke before step", 32'(cke_o), 32'd0);
          prev_w    = int'(e.w);
          have_prev = 1;
        end
        ticks = 0;
      end else if (us_tick_i && busy_o) begin
        ticks++;
      end
      if (ready_o && !ready_d && have_prev) begin
        check(ticks == prev_w, "R7 final wait", 32'(ticks), 32'(prev_w));
        have_prev = 0;
      end
      ready_d = ready_o;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    type_ddr1_i = 1'b0;
    refresh_cfg_i = 16'h0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(busy_o == 1'b0, "R1 busy", 32'(busy_o), 32'd0);
    check(ready_o == 1'b0, "R1 ready", 32'(ready_o), 32'd0);
    check(cke_o == 1'b0, "R1 cke", 32'(cke_o), 32'd0);
    check(op_stb_o == 1'b0 && op_kind_o == 3'd0, "R1 strobe",
          {28'd0, op_stb_o, op_kind_o}, 32'd0);
    mon_en = 1'b1;

    run_seq(1'b0, 16'h0c35, 1'b0);   // second-generation script
    run_seq(1'b1, 16'h0618, 1'b0);   // first-generation script
    run_seq(1'b0, 16'h1234, 1'b1);   // R3 / R9: type flip and start while busy

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule